// File: doc/BRIEF.md
# Host Interrupt Generator with Sense Control

This block drives one host interrupt pin from two request sources: data waiting in the receive path, and free room in the transmit path. A serial command front end decodes host messages and hands this block three kinds of single-cycle strobe. Each strobe comes with an 8-bit parameter: an enable request, a disable request, and a transmit-interrupt dismiss. The block also receives the current receive byte count, the current transmit free-space count, and a pulse that marks a completed host write.

The enable strobe can only turn per-source enables on, and the disable strobe can only turn them off. The pin polarity comes from the parameter of the latest enable strobe. A dismiss strobe hides the transmit request until the host writes new transmit data. The ORed request is converted to the chosen polarity and registered, so the pin never glitches.

Top module: `host_irq_gen`

## Requirements
- R1: On `irq_en_vld`, a 1 in `irq_parm` bit 0 sets the RX enable and a 1 in bit 1 sets the TX enable. Bits 2 to 6 have no effect.
- R2: On `irq_en_vld`, a 0 in bit 0 or bit 1 leaves that enable unchanged (set-only).
- R3: On `irq_dis_vld`, a 1 in bit 0 clears the RX enable and a 1 in bit 1 clears the TX enable. A 0 leaves the enable unchanged, and bits 2 to 7 have no effect.
- R4: The sense flag is loaded from bit 7 of every `irq_en_vld` parameter (1 = active-high pin, 0 = active-low pin). No other strobe changes it.
- R5: The RX request is active while the RX enable is set and `rx_avail` is nonzero. It drops once `rx_avail` returns to zero.
- R6: The TX request is active while the TX enable is set, `tx_room` is nonzero and the TX dismiss flag is clear.
- R7: `irq_txclr_vld` sets the TX dismiss flag and `host_wr_done` clears it. When both arrive in the same cycle, the dismiss wins.
- R8: The pin is registered. It equals (RX request OR TX request) when sense is 1 and the inverse when sense is 0. A count change shows at the pin after one rising edge. A strobe shows after two rising edges.
- R9: After reset, both enables and the dismiss flag are 0, sense is 0 (active low), and `irq_pin` is 1.
- R10: When `irq_en_vld` and `irq_dis_vld` arrive in the same cycle, each enable bit named by the disable parameter ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_en_vld | input | 1 | Enable command strobe |
| irq_dis_vld | input | 1 | Disable command strobe |
| irq_txclr_vld | input | 1 | Transmit-interrupt dismiss strobe |
| irq_parm | input | PARM_W (8) | Parameter carried with the enable or disable strobe |
| rx_avail | input | RX_W (16) | Receive bytes waiting for the host |
| tx_room | input | TX_W (16) | Transmit bytes the block can accept |
| host_wr_done | input | 1 | Pulse marking a completed host write |
| irq_pin | output | 1 | Interrupt pin level |

## Verification
A wrong enable bit or sense flag stays hidden until the matching count is nonzero. Once that source is active, it shows at the pin two edges after the command, as a missing level, an extra level or an inverted level. For that reason the stimulus keeps both counts active for long stretches, and it also drives them to zero. A stuck dismiss flag shows at the pin only while TX is enabled, RX is quiet and room is available. The directed sequences set up exactly that situation, then hold it across a host write and check the pin on the edge after it.

// File: rtl/irq_pkg.sv
package irq_pkg;

   typedef struct packed {
      logic sense_hi;
      logic en_tx;
      logic en_rx;
   } irq_cfg_t;

   localparam int unsigned SRC_RX = 0;
   localparam int unsigned SRC_TX = 1;
   localparam int unsigned N_SRC  = 2;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_pkg::*;
#(
   parameter int unsigned PARM_W    = 8,
   parameter int unsigned SENSE_BIT = 7,
   parameter int unsigned TX_BIT    = 1,
   parameter int unsigned RX_BIT    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_vld,
   input  logic              dis_vld,
   input  logic [PARM_W-1:0] parm,
   output irq_cfg_t          cfg
);

   localparam logic [PARM_W-1:0] USED_MASK =
      (PARM_W'(1) << SENSE_BIT) | (PARM_W'(1) << TX_BIT) | (PARM_W'(1) << RX_BIT);

   logic parm_unused;
   assign parm_unused = ^(parm & ~USED_MASK);

   logic set_rx, set_tx, clr_rx, clr_tx;
   irq_cfg_t cfg_nxt;

   always_comb begin
      set_rx = en_vld  & parm[RX_BIT];
      set_tx = en_vld  & parm[TX_BIT];
      clr_rx = dis_vld & parm[RX_BIT];
      clr_tx = dis_vld & parm[TX_BIT];
      cfg_nxt          = cfg;
      // a set and a clear in the same cycle: clear wins (R10)
      cfg_nxt.en_rx    = (cfg.en_rx | set_rx) & ~clr_rx;
      cfg_nxt.en_tx    = (cfg.en_tx | set_tx) & ~clr_tx;
      if (en_vld) begin
         cfg_nxt.sense_hi = parm[SENSE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else begin
         cfg <= cfg_nxt;
      end
   end

endmodule

// File: rtl/irq_tx_gate.sv
module irq_tx_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_vld,
   input  logic wr_done,
   output logic supp
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         supp <= 1'b0;
      end else if (clr_vld) begin
         supp <= 1'b1;
      end else if (wr_done) begin
         supp <= 1'b0;
      end
   end

endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
   parameter int unsigned N_REQ = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] req,
   input  logic             sense_hi,
   output logic             pin
);

   logic any_req;
   logic pin_nxt;

   always_comb begin
      any_req = |req;
      pin_nxt = sense_hi ? any_req : ~any_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin <= 1'b1;
      end else begin
         pin <= pin_nxt;
      end
   end

endmodule

// File: rtl/host_irq_gen.sv
module host_irq_gen
   import irq_pkg::*;
#(
   parameter int unsigned PARM_W    = 8,
   parameter int unsigned RX_W      = 16,
   parameter int unsigned TX_W      = 16,
   parameter int unsigned SENSE_BIT = 7,
   parameter int unsigned TX_BIT    = 1,
   parameter int unsigned RX_BIT    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_en_vld,
   input  logic              irq_dis_vld,
   input  logic              irq_txclr_vld,
   input  logic [PARM_W-1:0] irq_parm,
   input  logic [RX_W-1:0]   rx_avail,
   input  logic [TX_W-1:0]   tx_room,
   input  logic              host_wr_done,
   output logic              irq_pin
);

   if (SENSE_BIT >= PARM_W || TX_BIT >= PARM_W || RX_BIT >= PARM_W) begin : g_bad_pos
      $error("host_irq_gen: parameter bit position outside PARM_W");
   end
   if (SENSE_BIT == TX_BIT || SENSE_BIT == RX_BIT || TX_BIT == RX_BIT) begin : g_bad_overlap
      $error("host_irq_gen: parameter bit positions must differ");
   end
   if (RX_W < 1 || TX_W < 1) begin : g_bad_width
      $error("host_irq_gen: count widths must be at least 1");
   end

   irq_cfg_t         cfg;
   logic             tx_supp;
   logic [N_SRC-1:0] src_lvl;
   logic [N_SRC-1:0] src_en;
   logic [N_SRC-1:0] src_req;

   irq_cfg_regs #(
      .PARM_W    (PARM_W),
      .SENSE_BIT (SENSE_BIT),
      .TX_BIT    (TX_BIT),
      .RX_BIT    (RX_BIT)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_vld  (irq_en_vld),
      .dis_vld (irq_dis_vld),
      .parm    (irq_parm),
      .cfg     (cfg)
   );

   irq_tx_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_vld (irq_txclr_vld),
      .wr_done (host_wr_done),
      .supp    (tx_supp)
   );

   assign src_lvl[SRC_RX] = |rx_avail;
   assign src_lvl[SRC_TX] = (|tx_room) & ~tx_supp;
   assign src_en[SRC_RX]  = cfg.en_rx;
   assign src_en[SRC_TX]  = cfg.en_tx;

   for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
      assign src_req[gi] = src_lvl[gi] & src_en[gi];
   end

   irq_pin_drv #(
      .N_REQ (N_SRC)
   ) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (src_req),
      .sense_hi (cfg.sense_hi),
      .pin      (irq_pin)
   );

endmodule

// File: rtl/irq_chk.sv
module irq_chk #(
   parameter int unsigned PARM_W    = 8,
   parameter int unsigned RX_W      = 16,
   parameter int unsigned TX_W      = 16,
   parameter int unsigned SENSE_BIT = 7,
   parameter int unsigned TX_BIT    = 1,
   parameter int unsigned RX_BIT    = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_en_vld,
   input logic              irq_dis_vld,
   input logic              irq_txclr_vld,
   input logic [PARM_W-1:0] irq_parm,
   input logic [RX_W-1:0]   rx_avail,
   input logic [TX_W-1:0]   tx_room,
   input logic              host_wr_done,
   input logic              irq_pin,
   input logic              en_rx_q,
   input logic              en_tx_q,
   input logic              sense_q,
   input logic              supp_q
);

   // R2: an enable strobe never clears a set enable unless a disable joins it
   p_set_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_vld && !irq_dis_vld && en_rx_q) |=> en_rx_q);

   // R3 / R10: a disable bit always wins
   p_dis_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_dis_vld && irq_parm[TX_BIT]) |=> !en_tx_q);

   // R4: sense follows the latest enable parameter
   p_sense_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en_vld |=> (sense_q == $past(irq_parm[SENSE_BIT])));

   p_sense_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_vld |=> $stable(sense_q));

   // R5 / R8: an enabled RX request drives the pin active
   p_rx_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_rx_q && (rx_avail != '0)) |=> (irq_pin == $past(sense_q)));

   // R7: dismiss sets the flag even with a concurrent write
   p_dismiss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_txclr_vld |=> supp_q);

   // R8: nothing enabled means the pin sits inactive
   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_rx_q && !en_tx_q) |=> (irq_pin == !$past(sense_q)));

endmodule

bind host_irq_gen irq_chk #(
   .PARM_W    (PARM_W),
   .RX_W      (RX_W),
   .TX_W      (TX_W),
   .SENSE_BIT (SENSE_BIT),
   .TX_BIT    (TX_BIT),
   .RX_BIT    (RX_BIT)
) u_irq_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .irq_en_vld    (irq_en_vld),
   .irq_dis_vld   (irq_dis_vld),
   .irq_txclr_vld (irq_txclr_vld),
   .irq_parm      (irq_parm),
   .rx_avail      (rx_avail),
   .tx_room       (tx_room),
   .host_wr_done  (host_wr_done),
   .irq_pin       (irq_pin),
   .en_rx_q       (cfg.en_rx),
   .en_tx_q       (cfg.en_tx),
   .sense_q       (cfg.sense_hi),
   .supp_q        (tx_supp)
);

// File: tb/tb_host_irq_gen.sv
module tb_host_irq_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_en_vld = 1'b0;
   logic        irq_dis_vld = 1'b0;
   logic        irq_txclr_vld = 1'b0;
   logic [7:0]  irq_parm = '0;
   logic [15:0] rx_avail = '0;
   logic [15:0] tx_room = '0;
   logic        host_wr_done = 1'b0;
   logic        irq_pin;

   int n_chk  = 0;
   int n_fail = 0;

   // bench model state
   logic m_rx = 0, m_tx = 0, m_sense = 0, m_supp = 0;
   logic exp_pin = 1'b1;

   always #10 clk = ~clk;

   host_irq_gen dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .irq_en_vld    (irq_en_vld),
      .irq_dis_vld   (irq_dis_vld),
      .irq_txclr_vld (irq_txclr_vld),
      .irq_parm      (irq_parm),
      .rx_avail      (rx_avail),
      .tx_room       (tx_room),
      .host_wr_done  (host_wr_done),
      .irq_pin       (irq_pin)
   );

   function automatic logic pin_of(input logic erx, input logic etx, input logic sns,
                                   input logic sup, input logic [15:0] rxc,
                                   input logic [15:0] txf);
      logic req;
      req = (erx && rxc != 0) || (etx && !sup && txf != 0);
      return sns ? req : ~req;
   endfunction

   task automatic check(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s irq_pin actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: model follows the requirements, compared at the falling edge
   task automatic cyc(input string tag);
      @(posedge clk);
      exp_pin = pin_of(m_rx, m_tx, m_sense, m_supp, rx_avail, tx_room);
      if (irq_en_vld) begin
         m_rx = m_rx | irq_parm[0];
         m_tx = m_tx | irq_parm[1];
         m_sense = irq_parm[7];
      end
      if (irq_dis_vld) begin
         m_rx = m_rx & ~irq_parm[0];
         m_tx = m_tx & ~irq_parm[1];
      end
      if (irq_txclr_vld) m_supp = 1'b1;
      else if (host_wr_done) m_supp = 1'b0;
      @(negedge clk);
      check(tag, irq_pin, exp_pin);
   endtask

   task automatic strobe(input int kind, input logic [7:0] p, input string tag);
      irq_parm = p;
      irq_en_vld  = (kind == 0);
      irq_dis_vld = (kind == 1);
      irq_txclr_vld = (kind == 2);
      cyc(tag);
      irq_en_vld = 0; irq_dis_vld = 0; irq_txclr_vld = 0; irq_parm = '0;
   endtask

   initial begin : watchdog
      #(20 * 150000);
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      seed = 32'd2024;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check("R9 reset level", irq_pin, 1'b1);
      rst_n = 1'b1;
      rx_avail = 16'd5; tx_room = 16'd9;
      cyc("R9 idle after reset");
      cyc("R9 idle after reset");

      // R1: the 0x82 example enables only TX, active high
      strobe(0, 8'h82, "R1 enable 0x82");
      cyc("R1 tx active-high");
      check("R1 pin high with tx room", irq_pin, 1'b1);
      tx_room = 0; cyc("R6 no room");
      check("R6 pin low without room", irq_pin, 1'b0);

      // R1: bits 2..6 ignored, sense bit kept high
      strobe(0, 8'hFC, "R1 ignored bits");
      cyc("R1 ignored bits");
      check("R1 rx still disabled", irq_pin, 1'b0);

      // R2: a zero bit does not clear
      strobe(0, 8'h81, "R2 add rx");
      tx_room = 16'd3;
      strobe(0, 8'h80, "R2 zero bits");
      rx_avail = 0; cyc("R2 tx kept");
      check("R2 tx still enabled", irq_pin, 1'b1);

      // R3 and R4: disable tx, sense unchanged
      strobe(1, 8'h02, "R3 disable tx");
      cyc("R3 tx off");
      check("R3 pin inactive high-sense", irq_pin, 1'b0);
      rx_avail = 16'd1; cyc("R5 rx level");
      check("R5 rx active", irq_pin, 1'b1);
      strobe(1, 8'hFC, "R3 ignored bits");
      cyc("R3 rx kept");
      check("R3 rx survives ignored bits", irq_pin, 1'b1);
      rx_avail = 0; cyc("R5 rx drained");
      check("R5 drop when empty", irq_pin, 1'b0);

      // R4: sense low through an enable, not a disable
      strobe(0, 8'h02, "R4 active low");
      cyc("R4 active low");
      check("R4 pin low when tx active", irq_pin, 1'b0);
      strobe(1, 8'h80, "R4 disable no sense");
      cyc("R4 sense kept");
      check("R4 disable keeps sense", irq_pin, 1'b0);

      // R7: dismiss until write; simultaneous dismiss and write
      strobe(2, 8'h00, "R7 dismiss");
      cyc("R7 suppressed");
      check("R7 suppressed inactive", irq_pin, 1'b1);
      irq_txclr_vld = 1; host_wr_done = 1; cyc("R7 both");
      irq_txclr_vld = 0; host_wr_done = 0;
      cyc("R7 dismiss wins");
      check("R7 still suppressed", irq_pin, 1'b1);
      host_wr_done = 1; cyc("R7 write"); host_wr_done = 0;
      cyc("R7 re-armed");
      check("R7 re-armed after write", irq_pin, 1'b0);

      // R10: simultaneous enable and disable of rx
      irq_en_vld = 1; irq_dis_vld = 1; irq_parm = 8'h81;
      cyc("R10 both strobes");
      irq_en_vld = 0; irq_dis_vld = 0; irq_parm = 0;
      rx_avail = 16'd4; tx_room = 0;
      cyc("R10 rx cleared");
      check("R10 disable wins", irq_pin, 1'b0);

      // R8 and all: random mix, every cycle against the model
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         r = $urandom_range(0, 99);
         irq_parm = 8'($urandom());
         irq_en_vld    = (r < 6);
         irq_dis_vld   = (r >= 6 && r < 11) || (r == 99);
         irq_txclr_vld = (r >= 11 && r < 15);
         host_wr_done  = ($urandom_range(0, 9) == 0);
         if ($urandom_range(0, 3) == 0) rx_avail = ($urandom_range(0, 1) == 0) ? 16'd0 : 16'($urandom());
         if ($urandom_range(0, 3) == 0) tx_room  = ($urandom_range(0, 1) == 0) ? 16'd0 : 16'($urandom());
         cyc("R8 random");
      end
      irq_en_vld = 0; irq_dis_vld = 0; irq_txclr_vld = 0; host_wr_done = 0;

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule